// File: doc/BRIEF.md
# Packet-Command Sector Read Sequencer

This block is a host-side engine that fetches exactly one 2048-byte sector from a packet-command optical drive attached to a generic task-file bus. A single `start` pulse with a 32-bit logical block number and a drive-select bit launches the whole exchange. The block first keeps the channel's interrupt output enabled and addresses the chosen drive, then lets it settle. Next it asks for programmed-I/O transfers of 2048 bytes and issues the packet command. It then pushes a 12-byte read command through the data register as six 16-bit words.

Once the command packet has gone out, the data phase is paced by the drive's interrupt line, not by a timer. The sequencer waits for the interrupt and checks the drive status. It then reads 1024 data words and hands each one to the host as a one-cycle valid strobe. It waits for a second interrupt and polls until the drive reports neither busy nor data-request. A one-cycle `done` pulse ends the operation and carries a result code. Any status failure found during a checked poll stops the sequence early.

Top module: `atapi_rd_seq`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done`, `tf_req`, `hw_valid` and `err_code` are all 0 until a start is accepted.
- R2: An accepted start first writes 0x00 to the control register (address 8, interrupt-disable bit 1 kept at 0). It then writes the select register (address 6) with the slave bit in bit 4 and all other bits 0. It then performs exactly four reads of the alternate-status register (address 8).
- R3: After the settle reads, the block writes 0x00 to the features register (address 1). It then writes 0x00 to the count-low register (address 4) and 0x08 to the count-high register (address 5). Finally it writes the packet opcode 0xA0 to the command register (address 7).
- R4: A checked poll reads address 7 again while status bit 7 (busy) is 1. Once bit 7 is 0, the result is decided in this priority order: bit 0 set gives code 2; otherwise bit 5 set gives code 1; otherwise bit 3 (data request) clear gives code 3. Any of these codes ends the run with `done` and no further bus access.
- R5: After a passing checked poll of the command, the block writes six words to the data register (address 0), low byte first from the 12-byte packet. The packet has 0xA8 in byte 0, the block number most significant byte first in bytes 2 to 5, 0x01 in byte 9, and zeros in every other byte.
- R6: After the last packet word and after the last data word, no bus request is made until an interrupt has been seen. An interrupt pulse that arrives after the start, even while the packet is still being sent, is remembered and satisfies the wait.
- R7: After the first interrupt and a passing checked poll, the block reads address 0 exactly 1024 times. Each value read appears on `hw_data` with `hw_valid` high for one cycle, in the cycle after the bus acknowledge.
- R8: After the second interrupt, the block reads address 7 until both bit 7 and bit 3 are 0. It then raises `done` for one cycle with `err_code` 0, and `busy` is low in that cycle.
- R9: A start pulse while `busy` is high has no effect: the packet carries the block number latched at the accepted start, and no second sequence follows.
- R10: A bus request holds `tf_addr`, `tf_we` and `tf_wdata` steady until the cycle in which `tf_ack` is seen.
- R11: An interrupt pulse that arrives before the start is discarded and does not satisfy either interrupt wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sector read (sampled while idle) |
| lba | input | 32 | Logical block number to read |
| slave | input | 1 | Drive select: 0 first drive, 1 second drive |
| irq | input | 1 | Drive interrupt, one-cycle pulse |
| tf_req | output | 1 | Task-file access request |
| tf_we | output | 1 | 1 for write, 0 for read |
| tf_addr | output | 4 | Register address (0-7 command block, 8 control/alternate status) |
| tf_wdata | output | 16 | Write data |
| tf_ack | input | 1 | Access complete; read data valid |
| tf_rdata | input | 16 | Read data |
| hw_valid | output | 1 | Sector word valid strobe |
| hw_data | output | 16 | Sector word |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| err_code | output | 2 | Result: 0 ok, 1 device fault, 2 error bit, 3 no data request |

## Verification
The drive model answers polls with a scripted number of busy replies per poll group, and the sequence is run under several patterns. Two clean runs differ in block number, drive select and interrupt timing. In one of them the interrupt arrives while packet words are still being written, which shows whether the pending interrupt is latched or lost. Other runs put a stale interrupt before the start, which tells a cleared latch from a leaky one, and send a start pulse mid-run, which separates a properly latched block number from a re-captured one. Failing status values are given as error plus fault, fault plus data-request, and data-request missing. These show the priority order and the early stop. The final poll group answers data-request without busy, which tells a poll that waits on both bits from one that waits on busy alone.

// File: rtl/atapi_rd_pkg.sv
package atapi_rd_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_NIEN,
    ST_SEL,
    ST_SETTLE,
    ST_FEAT,
    ST_CNT_LO,
    ST_CNT_HI,
    ST_CMD,
    ST_POLL_CMD,
    ST_PKT,
    ST_WAIT_DATA,
    ST_POLL_DATA,
    ST_XFER,
    ST_WAIT_END,
    ST_POLL_END
  } seq_state_t;

  typedef enum logic [1:0] {
    RES_OK     = 2'd0,
    RES_FAULT  = 2'd1,
    RES_ABORT  = 2'd2,
    RES_NO_DRQ = 2'd3
  } result_t;

  localparam logic [3:0] TF_DATA    = 4'd0;
  localparam logic [3:0] TF_FEAT    = 4'd1;
  localparam logic [3:0] TF_CNT_LO  = 4'd4;
  localparam logic [3:0] TF_CNT_HI  = 4'd5;
  localparam logic [3:0] TF_DEVSEL  = 4'd6;
  localparam logic [3:0] TF_CMDSTAT = 4'd7;
  localparam logic [3:0] TF_CTRL    = 4'd8;

  localparam logic [7:0] OP_PACKET   = 8'hA0;
  localparam logic [7:0] OP_SCSI_RD  = 8'hA8;

  localparam int SB_BSY = 7;
  localparam int SB_DF  = 5;
  localparam int SB_DRQ = 3;
  localparam int SB_ERR = 0;
  localparam int DEVSEL_DRV_BIT = 4;

endpackage

// File: rtl/atapi_rd_irq_latch.sv
module atapi_rd_irq_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic irq,
  input  logic clear,
  output logic pend
);
  logic pend_nx;

  // A pulse in the same cycle as a clear is kept.
  always_comb begin
    pend_nx = (pend & ~clear) | irq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= pend_nx;
  end

  assert_irq_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> pend);

endmodule

// File: rtl/atapi_rd_packet.sv
module atapi_rd_packet #(
  parameter int LBA_W     = 32,
  parameter int PKT_BYTES = 12,
  parameter int WORD_W    = 16,
  localparam int PKT_WORDS = PKT_BYTES / 2,
  localparam int IDX_W     = $clog2(PKT_WORDS),
  localparam int LBA_BYTES = LBA_W / 8
) (
  input  logic [LBA_W-1:0]  lba,
  input  logic [IDX_W-1:0]  idx,
  output logic [WORD_W-1:0] word
);
  import atapi_rd_pkg::*;

  localparam int LBA_POS = 2;
  localparam int CNT_POS = 9;

  logic [7:0]        pkt_b [PKT_BYTES];
  logic [WORD_W-1:0] pkt_w [PKT_WORDS];

  always_comb begin
    for (int i = 0; i < PKT_BYTES; i++) pkt_b[i] = 8'h00;
    pkt_b[0] = OP_SCSI_RD;
    for (int k = 0; k < LBA_BYTES; k++)
      pkt_b[LBA_POS + k] = lba[LBA_W-1-8*k -: 8];
    pkt_b[CNT_POS] = 8'h01;
  end

  for (genvar w = 0; w < PKT_WORDS; w++) begin : g_word
    assign pkt_w[w] = {pkt_b[2*w+1], pkt_b[2*w]};
  end

  always_comb begin
    word = '0;
    for (int w = 0; w < PKT_WORDS; w++)
      if (idx == IDX_W'(w)) word = pkt_w[w];
  end

endmodule

// File: rtl/atapi_rd_status_eval.sv
module atapi_rd_status_eval (
  input  logic                  chk_mode,
  input  logic [7:0]            stat,
  output logic                  retry,
  output logic                  fail,
  output atapi_rd_pkg::result_t code
);
  import atapi_rd_pkg::*;

  always_comb begin
    retry = 1'b0;
    fail  = 1'b0;
    code  = RES_OK;
    if (!chk_mode) begin
      retry = stat[SB_BSY] | stat[SB_DRQ];
    end else if (stat[SB_BSY]) begin
      retry = 1'b1;
    end else if (stat[SB_ERR]) begin
      fail = 1'b1;
      code = RES_ABORT;
    end else if (stat[SB_DF]) begin
      fail = 1'b1;
      code = RES_FAULT;
    end else if (!stat[SB_DRQ]) begin
      fail = 1'b1;
      code = RES_NO_DRQ;
    end
  end

endmodule

// File: rtl/atapi_rd_seq.sv
module atapi_rd_seq #(
  parameter int LBA_W        = 32,
  parameter int SECTOR_BYTES = 2048,
  parameter int SETTLE_READS = 4,
  parameter int PKT_BYTES    = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LBA_W-1:0]  lba,
  input  logic              slave,
  input  logic              irq,
  output logic              tf_req,
  output logic              tf_we,
  output logic [3:0]        tf_addr,
  output logic [15:0]       tf_wdata,
  input  logic              tf_ack,
  input  logic [15:0]       tf_rdata,
  output logic              hw_valid,
  output logic [15:0]       hw_data,
  output logic              busy,
  output logic              done,
  output logic [1:0]        err_code
);
  import atapi_rd_pkg::*;

  localparam int WORDS     = SECTOR_BYTES / 2;
  localparam int PKT_WORDS = PKT_BYTES / 2;
  localparam int IDX_W     = $clog2(PKT_WORDS);
  localparam int CNT_W     = $clog2(WORDS + PKT_WORDS + SETTLE_READS);
  localparam logic [15:0] BYTE_CNT = 16'(SECTOR_BYTES);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign srst_n = rst_pipe[1];

  seq_state_t       state, state_nx;
  logic [LBA_W-1:0] lba_q;
  logic             slave_q;
  logic [CNT_W-1:0] cnt, cnt_nx;
  logic             cnt_clr, cnt_inc;
  logic             load_en;
  logic             done_nx;
  result_t          res_nx;
  logic             res_en;
  logic [1:0]       res_q;
  logic             irq_pend, irq_clr;
  logic [15:0]      pkt_word;
  logic             st_retry, st_fail;
  result_t          st_code;
  logic             chk_mode;
  logic             xfer_beat;

  atapi_rd_irq_latch u_irq (
    .clk   (clk),
    .rst_n (srst_n),
    .irq   (irq),
    .clear (irq_clr),
    .pend  (irq_pend)
  );

  atapi_rd_packet #(
    .LBA_W     (LBA_W),
    .PKT_BYTES (PKT_BYTES),
    .WORD_W    (16)
  ) u_pkt (
    .lba  (lba_q),
    .idx  (cnt[IDX_W-1:0]),
    .word (pkt_word)
  );

  assign chk_mode = (state != ST_POLL_END);

  atapi_rd_status_eval u_stat (
    .chk_mode (chk_mode),
    .stat     (tf_rdata[7:0]),
    .retry    (st_retry),
    .fail     (st_fail),
    .code     (st_code)
  );

  // bus drive per state
  always_comb begin
    tf_req   = 1'b1;
    tf_we    = 1'b0;
    tf_addr  = TF_CMDSTAT;
    tf_wdata = 16'h0000;
    unique case (state)
      ST_NIEN:   begin tf_we = 1'b1; tf_addr = TF_CTRL; end
      ST_SEL:    begin
        tf_we = 1'b1;
        tf_addr = TF_DEVSEL;
        tf_wdata[DEVSEL_DRV_BIT] = slave_q;
      end
      ST_SETTLE: tf_addr = TF_CTRL;
      ST_FEAT:   begin tf_we = 1'b1; tf_addr = TF_FEAT; end
      ST_CNT_LO: begin tf_we = 1'b1; tf_addr = TF_CNT_LO; tf_wdata = {8'h00, BYTE_CNT[7:0]}; end
      ST_CNT_HI: begin tf_we = 1'b1; tf_addr = TF_CNT_HI; tf_wdata = {8'h00, BYTE_CNT[15:8]}; end
      ST_CMD:    begin tf_we = 1'b1; tf_addr = TF_CMDSTAT; tf_wdata = {8'h00, OP_PACKET}; end
      ST_POLL_CMD, ST_POLL_DATA, ST_POLL_END: tf_addr = TF_CMDSTAT;
      ST_PKT:    begin tf_we = 1'b1; tf_addr = TF_DATA; tf_wdata = pkt_word; end
      ST_XFER:   tf_addr = TF_DATA;
      default:   tf_req = 1'b0;
    endcase
  end

  // next state
  always_comb begin
    state_nx = state;
    cnt_clr  = 1'b0;
    cnt_inc  = 1'b0;
    load_en  = 1'b0;
    irq_clr  = 1'b0;
    done_nx  = 1'b0;
    res_nx   = RES_OK;
    res_en   = 1'b0;
    unique case (state)
      ST_IDLE: if (start) begin
        state_nx = ST_NIEN;
        load_en  = 1'b1;
        irq_clr  = 1'b1;
        cnt_clr  = 1'b1;
        res_en   = 1'b1;
      end
      ST_NIEN:   if (tf_ack) state_nx = ST_SEL;
      ST_SEL:    if (tf_ack) state_nx = ST_SETTLE;
      ST_SETTLE: if (tf_ack) begin
        if (cnt == CNT_W'(SETTLE_READS - 1)) begin
          state_nx = ST_FEAT;
          cnt_clr  = 1'b1;
        end else cnt_inc = 1'b1;
      end
      ST_FEAT:   if (tf_ack) state_nx = ST_CNT_LO;
      ST_CNT_LO: if (tf_ack) state_nx = ST_CNT_HI;
      ST_CNT_HI: if (tf_ack) state_nx = ST_CMD;
      ST_CMD:    if (tf_ack) state_nx = ST_POLL_CMD;
      ST_POLL_CMD, ST_POLL_DATA, ST_POLL_END: if (tf_ack && !st_retry) begin
        if (st_fail) begin
          state_nx = ST_IDLE;
          done_nx  = 1'b1;
          res_nx   = st_code;
          res_en   = 1'b1;
        end else begin
          cnt_clr = 1'b1;
          unique case (state)
            ST_POLL_CMD:  state_nx = ST_PKT;
            ST_POLL_DATA: state_nx = ST_XFER;
            default: begin
              state_nx = ST_IDLE;
              done_nx  = 1'b1;
              res_en   = 1'b1;
            end
          endcase
        end
      end
      ST_PKT: if (tf_ack) begin
        if (cnt == CNT_W'(PKT_WORDS - 1)) begin
          state_nx = ST_WAIT_DATA;
          cnt_clr  = 1'b1;
        end else cnt_inc = 1'b1;
      end
      ST_WAIT_DATA: if (irq_pend) begin
        state_nx = ST_POLL_DATA;
        irq_clr  = 1'b1;
      end
      ST_XFER: if (tf_ack) begin
        if (cnt == CNT_W'(WORDS - 1)) begin
          state_nx = ST_WAIT_END;
          cnt_clr  = 1'b1;
        end else cnt_inc = 1'b1;
      end
      ST_WAIT_END: if (irq_pend) begin
        state_nx = ST_POLL_END;
        irq_clr  = 1'b1;
      end
      default: state_nx = ST_IDLE;
    endcase
  end

  always_comb begin
    cnt_nx = cnt;
    if (cnt_clr)      cnt_nx = '0;
    else if (cnt_inc) cnt_nx = cnt + CNT_W'(1);
  end

  assign xfer_beat = (state == ST_XFER) && tf_ack;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      lba_q    <= '0;
      slave_q  <= 1'b0;
      res_q    <= 2'b00;
      done     <= 1'b0;
      hw_valid <= 1'b0;
      hw_data  <= 16'h0000;
    end else begin
      state    <= state_nx;
      cnt      <= cnt_nx;
      done     <= done_nx;
      hw_valid <= xfer_beat;
      if (load_en) begin
        lba_q   <= lba;
        slave_q <= slave;
      end
      if (res_en)    res_q   <= res_nx;
      if (xfer_beat) hw_data <= tf_rdata;
    end
  end

  assign busy     = (state != ST_IDLE);
  assign err_code = res_q;

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!srst_n)
    tf_req && !tf_ack |=> tf_req && $stable(tf_addr) && $stable(tf_we) && $stable(tf_wdata));

  assert_nien_low_R2: assert property (@(posedge clk) disable iff (!srst_n)
    tf_req && tf_we && tf_addr == TF_CTRL |-> tf_wdata[1] == 1'b0);

  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!srst_n)
    busy && start |=> $stable(lba_q) && $stable(slave_q));

  assert_word_source_R7: assert property (@(posedge clk) disable iff (!srst_n)
    hw_valid |-> $past(tf_ack && tf_req && !tf_we && tf_addr == TF_DATA));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!srst_n)
    done |-> !busy ##1 !done);

  assert_cnt_range_R7: assert property (@(posedge clk) disable iff (!srst_n)
    cnt < CNT_W'(WORDS));

endmodule

// File: tb/atapi_rd_seq_bench.sv
module atapi_rd_seq_bench;

  localparam int WORDS = 1024;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [31:0] lba;
  logic        slave;
  logic        irq;
  logic        irq_model, irq_stale;
  logic        tf_req, tf_we;
  logic [3:0]  tf_addr;
  logic [15:0] tf_wdata;
  logic        tf_ack;
  logic [15:0] tf_rdata;
  logic        hw_valid;
  logic [15:0] hw_data;
  logic        busy, done;
  logic [1:0]  err_code;

  always #2 clk = ~clk;

  assign irq = irq_model | irq_stale;

  atapi_rd_seq u_atapi_rd_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .lba(lba), .slave(slave), .irq(irq),
    .tf_req(tf_req), .tf_we(tf_we), .tf_addr(tf_addr), .tf_wdata(tf_wdata),
    .tf_ack(tf_ack), .tf_rdata(tf_rdata), .hw_valid(hw_valid), .hw_data(hw_data),
    .busy(busy), .done(done), .err_code(err_code)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive model state
  int          busy_n [3];
  logic [7:0]  stat_ok [3];
  int          d1, d2, early_at;
  int          grp, greads, pkt_acks, data_acks, data_issued, irq_cnt;
  bit          last_stat, waiting, irq_seen, running;
  logic [3:0]  pend_addr;
  string       wait_tag;
  logic [20:0] log_q [$];
  logic [15:0] exp_q [$];

  always @(posedge clk) begin
    if (!rst_n) begin
      tf_ack    <= 1'b0;
      tf_rdata  <= 16'h0000;
      irq_model <= 1'b0;
    end else begin
      irq_model <= 1'b0;
      if (irq_cnt > 0) begin
        irq_cnt--;
        if (irq_cnt == 0) begin
          irq_model <= 1'b1;
          irq_seen = 1'b1;
          waiting  = 1'b0;
        end
      end
      if (tf_ack) begin
        chk(tf_addr == pend_addr, "R10 address held", 32'(tf_addr), 32'(pend_addr));
        if (tf_we && tf_addr == 4'd0) begin
          pkt_acks++;
          if (pkt_acks == early_at) irq_cnt = 1;
          if (pkt_acks == 6 && early_at < 0) begin
            irq_cnt = d1;
            waiting = !irq_seen;
          end
        end
        if (!tf_we && tf_addr == 4'd0) begin
          exp_q.push_back(tf_rdata);
          data_acks++;
          if (data_acks == WORDS) begin
            irq_cnt  = d2;
            irq_seen = 1'b0;
            waiting  = 1'b1;
          end
        end
        if (!(!tf_we && (tf_addr == 4'd0 || tf_addr == 4'd7)))
          log_q.push_back({tf_we, tf_addr, tf_we ? tf_wdata : 16'h0000});
      end
      tf_ack <= tf_req && !tf_ack;
      if (tf_req && !tf_ack) begin
        pend_addr = tf_addr;
        if (!tf_we && tf_addr == 4'd7) begin
          int gi;
          if (!last_stat) begin grp++; greads = 0; end
          last_stat = 1'b1;
          gi = (grp > 2) ? 2 : grp;
          if (greads < busy_n[gi]) tf_rdata <= (gi == 2) ? 16'h0008 : 16'h0080;
          else                     tf_rdata <= {8'h00, stat_ok[gi]};
          greads++;
        end else begin
          last_stat = 1'b0;
          if (!tf_we && tf_addr == 4'd0) begin
            tf_rdata <= 16'hC3A5 ^ 16'(data_issued * 37);
            data_issued++;
          end else tf_rdata <= 16'h0050;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (running) begin
      if (waiting) begin
        chk(!tf_req, {wait_tag, " no access while waiting for interrupt"}, 32'(tf_req), 0);
        if (tf_req) waiting = 1'b0;
      end
      if (hw_valid) begin
        if (exp_q.size() == 0) chk(1'b0, "R7 unexpected word strobe", 32'(hw_data), 0);
        else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          chk(hw_data == e, "R7 sector word", 32'(hw_data), 32'(e));
        end
      end
    end
  end

  function automatic logic [20:0] exp_entry(int i, logic [31:0] l, logic s);
    case (i)
      0:  return {1'b1, 4'd8, 16'h0000};
      1:  return {1'b1, 4'd6, 11'd0, s, 4'd0};
      2, 3, 4, 5: return {1'b0, 4'd8, 16'h0000};
      6:  return {1'b1, 4'd1, 16'h0000};
      7:  return {1'b1, 4'd4, 16'h0000};
      8:  return {1'b1, 4'd5, 16'h0008};
      9:  return {1'b1, 4'd7, 16'h00A0};
      10: return {1'b1, 4'd0, 16'h00A8};
      11: return {1'b1, 4'd0, l[23:16], l[31:24]};
      12: return {1'b1, 4'd0, l[7:0], l[15:8]};
      14: return {1'b1, 4'd0, 16'h0100};
      default: return {1'b1, 4'd0, 16'h0000};
    endcase
  endfunction

  task automatic run_case(input logic [31:0] l, input logic s,
                          input int b0, input int b1, input int b2,
                          input logic [7:0] s0, input logic [7:0] s1, input logic [7:0] s2,
                          input int dd1, input int dd2, input int early, input bit stale,
                          input bit glitch, input logic [1:0] exp_err,
                          input int exp_entries, input int exp_data, input string tag);
    int cyc;
    @(negedge clk);
    busy_n[0] = b0; busy_n[1] = b1; busy_n[2] = b2;
    stat_ok[0] = s0; stat_ok[1] = s1; stat_ok[2] = s2;
    d1 = dd1; d2 = dd2; early_at = early;
    grp = -1; greads = 0; pkt_acks = 0; data_acks = 0; data_issued = 0; irq_cnt = 0;
    last_stat = 1'b0; waiting = 1'b0;
    wait_tag = stale ? "R11" : "R6";
    log_q.delete(); exp_q.delete();
    if (stale) begin
      irq_stale = 1'b1;
      @(negedge clk);
      irq_stale = 1'b0;
      repeat (3) @(negedge clk);
    end
    irq_seen = 1'b0;
    lba = l; slave = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (glitch) begin
      repeat (5) @(negedge clk);
      chk(busy, "R9 busy during run", 32'(busy), 1);
      lba = ~l; slave = ~s; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    chk(done, {tag, " done reached"}, 32'(done), 1);
    chk(err_code == exp_err, {tag, " result code"}, 32'(err_code), 32'(exp_err));
    chk(!busy, "R8 busy low with done", 32'(busy), 0);
    @(negedge clk);
    chk(!done, "R8 done lasts one cycle", 32'(done), 0);
    begin
      bit idle = 1'b1;
      repeat (20) begin
        if (tf_req) idle = 1'b0;
        @(negedge clk);
      end
      chk(idle, glitch ? "R9 no second sequence" : {tag, " bus quiet after done"}, 32'(!idle), 0);
    end
    chk(log_q.size() == exp_entries, {tag, " register access count"}, 32'(log_q.size()), 32'(exp_entries));
    for (int i = 0; i < exp_entries && i < log_q.size(); i++) begin
      logic [20:0] e;
      e = exp_entry(i, l, s);
      chk(log_q[i] == e, (i < 6) ? "R2 setup access" : (i < 10) ? "R3 program access" : "R5 packet word",
          32'(log_q[i]), 32'(e));
    end
    if (glitch && log_q.size() > 12)
      chk(log_q[11] == exp_entry(11, l, s) && log_q[12] == exp_entry(12, l, s),
          "R9 packet keeps first block number", 32'(log_q[12]), 32'(exp_entry(12, l, s)));
    chk(data_acks == exp_data, "R7 data read count", 32'(data_acks), 32'(exp_data));
    chk(exp_q.size() == 0, "R7 all words delivered", 32'(exp_q.size()), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; lba = '0; slave = 1'b0; irq_stale = 1'b0;
    running = 1'b0; irq_cnt = 0; waiting = 1'b0;
    repeat (4) @(negedge clk);
    chk(!busy && !done && !tf_req && !hw_valid && err_code == 2'd0, "R1 reset state",
        {busy, done, tf_req, hw_valid, err_code}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !done && !tf_req && !hw_valid && err_code == 2'd0, "R1 idle after reset",
        {busy, done, tf_req, hw_valid, err_code}, 0);
    running = 1'b1;
    // clean read, start pulse mid-run, final poll holds on data-request
    run_case(32'h12345678, 1'b0, 2, 1, 3, 8'h08, 8'h08, 8'h00, 5, 3, -1, 1'b0, 1'b1, 2'd0, 16, WORDS, "R8");
    // interrupt arrives while packet words are being written
    run_case(32'hA1B2C3D4, 1'b1, 0, 0, 0, 8'h48, 8'h08, 8'h40, 0, 1, 3, 1'b0, 1'b0, 2'd0, 16, WORDS, "R6");
    // stale interrupt before start must be dropped
    run_case(32'h00000000, 1'b1, 1, 0, 1, 8'h08, 8'h08, 8'h00, 30, 25, -1, 1'b1, 1'b0, 2'd0, 16, WORDS, "R11");
    // error bit wins over fault on command poll
    run_case(32'h0BADF00D, 1'b0, 1, 0, 0, 8'h29, 8'h08, 8'h00, 2, 2, -1, 1'b0, 1'b0, 2'd2, 10, 0, "R4");
    // fault with data-request on data poll
    run_case(32'h7F00FF01, 1'b1, 0, 2, 0, 8'h08, 8'h28, 8'h00, 2, 2, -1, 1'b0, 1'b0, 2'd1, 16, 0, "R4");
    // missing data-request on command poll
    run_case(32'h00010203, 1'b0, 0, 0, 0, 8'h00, 8'h08, 8'h00, 2, 2, -1, 1'b0, 1'b0, 2'd3, 10, 0, "R4");
    running = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule